// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

After reset is released, and again each time its start input is pulsed, this block reads a 1-Kbit, 16-bit-word serial EEPROM over a four-wire Microwire link. It reads words 0 through 24 (byte offsets 00h to 31h) one at a time, in ascending order. The first word must hold the signature 8129h. If the signature is wrong, the run stops after that word and every loaded field goes back to its default of zero. If the signature is right, each word that carries a configuration field is copied into a holding register as soon as its last data bit has arrived. The registers cover the station address, the subsystem identifiers, two timer bytes, four configuration bytes and a media/control byte.

The media/control byte is not presented as a raw value. It is spread into three outputs: a media-status field, a basic-control field and an advertisement bit. The advertisement bit is the inverse of one of its bits, and only when auto-negotiation is selected. The vendor and device identifier outputs are constants and never come from the EEPROM.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is held, `busy` is high, `done` and `mw_cs` are low, and all loaded outputs are zero. After reset is released, a load starts without any `start` pulse.
- R2: Each read frame keeps `mw_cs` high and sends a 1 start bit, the opcode bits 1 then 0, and the 6-bit word address MSB first. It then ignores one dummy bit and captures 16 data bits MSB first on `mw_di`. Frames address words 0, 1, 2, … 24 in that order.
- R3: One `mw_sk` period lasts 2×HALF_DIV clock cycles. `mw_sk` is low whenever `mw_cs` is low. `mw_cs` stays low for at least one `mw_sk` period between frames.
- R4: If word 0 is not 8129h (byte 00h = 29h, byte 01h = 81h), the run ends after that single frame with `sig_ok` low, and every loaded output returns to zero.
- R5: `busy` rises on the cycle after an accepted `start` and falls when the run ends. `done` is then high for exactly one cycle, `busy` is low during that cycle, and `sig_ok` is valid from that cycle on.
- R6: A `start` pulse that arrives while `busy` is high has no effect. The run in progress continues with its next address and issues exactly 25 frames.
- R7: `vendor_id` is always 10ECh and `device_id` is always 8139h. The contents of bytes 02h–05h have no effect on any output.
- R8: `station_addr[8k+7:8k]` takes byte 0Eh+k for k = 0..5. Within every word, the lower byte address is bits 7:0 of the 16-bit word.
- R9: `sub_vendor_id` = {byte 07h, byte 06h}, `sub_id` = {byte 09h, byte 08h}, `min_grant` = byte 0Ah, `max_latency` = byte 0Bh, `cfg3` = byte 0Dh, `cfg0` = byte 14h, `cfg1` = byte 15h, `cfg4` = byte 1Eh.
- R10: With media byte M = byte 0Ch: `media_status` = {M[7:6], 6'b0}, and `basic_ctl` has bit 13 = M[5], bit 12 = M[4] (auto-negotiation select), bit 8 = M[0] and all other bits zero. M[3:2] affect no output.
- R11: `adv_pause` = M[4] AND NOT M[1]. A 0 in M[1] advertises pause flow control only when auto-negotiation is selected.
- R12: A loaded output changes only on the cycle after its own word has been fully received. Fields held in later words keep their previous values until those words arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a load when idle |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sig_ok | output | 1 | Signature matched in the last run |
| mw_cs | output | 1 | EEPROM chip select |
| mw_sk | output | 1 | EEPROM serial clock |
| mw_do | output | 1 | Serial data to EEPROM |
| mw_di | input | 1 | Serial data from EEPROM |
| vendor_id | output | 16 | Fixed vendor identifier |
| device_id | output | 16 | Fixed device identifier |
| sub_vendor_id | output | 16 | Loaded subsystem vendor identifier |
| sub_id | output | 16 | Loaded subsystem identifier |
| min_grant | output | 8 | Loaded minimum-grant timer byte |
| max_latency | output | 8 | Loaded maximum-latency timer byte |
| cfg0 | output | 8 | Loaded configuration byte 0 |
| cfg1 | output | 8 | Loaded configuration byte 1 |
| cfg3 | output | 8 | Loaded configuration byte 3 |
| cfg4 | output | 8 | Loaded configuration byte 4 |
| media_status | output | 8 | Media-status bits derived from the media byte |
| basic_ctl | output | 16 | Basic-control bits derived from the media byte |
| adv_pause | output | 1 | Pause-advertisement bit |
| station_addr | output | 48 | Loaded 6-byte station address |

## Verification
The EEPROM model is filled from a computed byte pattern. It is reloaded with a second, different pattern so that the order of the loads, and the point at which each field changes, can be seen. A swapped signature word separates a signature check on the word value from a check that fails to tell the bytes apart, and it shows whether the block aborts and clears. The media byte is swept over all 16 combinations of its mapped control bits while the high and ignored bits also vary. This separates bit-wise mistakes in the split, in the inversion and in the auto-negotiation gating. A second `start` pulse in the middle of a run shows whether the address sequence restarts.

// File: rtl/eeprom_cfg_pkg.sv
package eeprom_cfg_pkg;

    localparam logic [15:0] SIG_WORD  = 16'h8129;
    localparam logic [15:0] VENDOR_ID = 16'h10EC;
    localparam logic [15:0] DEVICE_ID = 16'h8139;
    localparam logic [1:0]  OP_READ   = 2'b10;

    // word indices of loaded fields (lower byte address = low half)
    localparam int W_SUBVEN = 3;   // bytes 06h/07h
    localparam int W_SUBID  = 4;   // bytes 08h/09h
    localparam int W_TIMERS = 5;   // 0Ah grant, 0Bh latency
    localparam int W_MEDIA  = 6;   // 0Ch media byte, 0Dh cfg3
    localparam int W_STA0   = 7;   // 0Eh..13h station address
    localparam int STA_WORDS = 3;
    localparam int W_CFG01  = 10;  // 14h cfg0, 15h cfg1
    localparam int W_CFG4   = 15;  // 1Eh cfg4

    typedef enum logic [1:0] {MW_IDLE, MW_SHIFT, MW_GAP} mw_state_e;
    typedef enum logic [1:0] {SQ_BOOT, SQ_ISSUE, SQ_WAIT, SQ_IDLE} sq_state_e;

    typedef struct packed {
        logic [15:0] sub_vendor;
        logic [15:0] sub_id;
        logic [7:0]  min_grant;
        logic [7:0]  max_lat;
        logic [7:0]  media;
        logic [7:0]  cfg3;
        logic [47:0] station;
        logic [7:0]  cfg0;
        logic [7:0]  cfg1;
        logic [7:0]  cfg4;
    } cfg_fields_t;

    localparam cfg_fields_t FIELD_DEFAULTS = '0;

endpackage

// File: rtl/ecl_serial.sv
module ecl_serial
    import eeprom_cfg_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int AW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] addr,
    output logic          done,
    output logic [15:0]   rdata,
    output logic          mw_cs,
    output logic          mw_sk,
    output logic          mw_do,
    input  logic          mw_di
);
    localparam int CMD_W      = AW + 3;
    localparam int DATA_START = CMD_W + 1;
    localparam int LAST_BIT   = CMD_W + 16;
    localparam int BIT_W      = $clog2(LAST_BIT + 1);
    localparam int GAP_CNT    = 2 * HALF_DIV;
    localparam int CNT_W      = $clog2(GAP_CNT + 1);

    typedef struct packed {
        mw_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bidx;
        logic             high;
        logic [CMD_W-1:0] cmd;
        logic [15:0]      data;
        logic             cs;
        logic             sk;
        logic             done;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            MW_IDLE: begin
                if (req) begin
                    s_d.st   = MW_SHIFT;
                    s_d.cnt  = '0;
                    s_d.bidx = '0;
                    s_d.high = 1'b0;
                    s_d.cs   = 1'b1;
                    s_d.sk   = 1'b0;
                    s_d.cmd  = {1'b1, OP_READ, addr};
                end
            end
            MW_SHIFT: begin
                if (s_q.cnt == CNT_W'(HALF_DIV - 1)) begin
                    s_d.cnt = '0;
                    if (!s_q.high) begin
                        s_d.high = 1'b1;
                        s_d.sk   = 1'b1;
                    end else begin
                        s_d.high = 1'b0;
                        s_d.sk   = 1'b0;
                        if (s_q.bidx >= BIT_W'(DATA_START))
                            s_d.data = {s_q.data[14:0], mw_di};
                        if (s_q.bidx == BIT_W'(LAST_BIT)) begin
                            s_d.st  = MW_GAP;
                            s_d.cs  = 1'b0;
                            s_d.cmd = '0;
                        end else begin
                            s_d.bidx = s_q.bidx + BIT_W'(1);
                            s_d.cmd  = s_q.cmd << 1;
                        end
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            MW_GAP: begin
                if (s_q.cnt == CNT_W'(GAP_CNT - 1)) begin
                    s_d.st   = MW_IDLE;
                    s_d.cnt  = '0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: s_d.st = MW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: MW_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done  = s_q.done;
    assign rdata = s_q.data;
    assign mw_cs = s_q.cs;
    assign mw_sk = s_q.sk;
    assign mw_do = s_q.cmd[CMD_W-1];

    // R3
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mw_cs |-> !mw_sk);
    // R3
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mw_cs) |=> !mw_cs);
    // R2
    req_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (s_q.st == MW_IDLE));
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/ecl_seq.sv
module ecl_seq
    import eeprom_cfg_pkg::*;
#(
    parameter int AW        = 6,
    parameter int LAST_WORD = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          eng_done,
    input  logic [15:0]   eng_data,
    output logic          eng_req,
    output logic [AW-1:0] eng_addr,
    output logic          wr_en,
    output logic          clr,
    output logic          busy,
    output logic          done,
    output logic          sig_ok
);
    typedef struct packed {
        sq_state_e     st;
        logic [AW-1:0] addr;
        logic          done;
        logic          ok;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        wr_en    = 1'b0;
        clr      = 1'b0;
        case (q_q.st)
            SQ_BOOT: begin
                q_d.st   = SQ_ISSUE;
                q_d.addr = '0;
                q_d.ok   = 1'b0;
            end
            SQ_IDLE: begin
                if (start) begin
                    q_d.st   = SQ_ISSUE;
                    q_d.addr = '0;
                    q_d.ok   = 1'b0;
                end
            end
            SQ_ISSUE: q_d.st = SQ_WAIT;
            SQ_WAIT: begin
                if (eng_done) begin
                    if (q_q.addr == '0 && eng_data != SIG_WORD) begin
                        clr      = 1'b1;
                        q_d.st   = SQ_IDLE;
                        q_d.done = 1'b1;
                        q_d.ok   = 1'b0;
                    end else begin
                        wr_en = 1'b1;
                        if (q_q.addr == AW'(LAST_WORD)) begin
                            q_d.st   = SQ_IDLE;
                            q_d.done = 1'b1;
                            q_d.ok   = 1'b1;
                        end else begin
                            q_d.addr = q_q.addr + AW'(1);
                            q_d.st   = SQ_ISSUE;
                        end
                    end
                end
            end
            default: q_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '{st: SQ_BOOT, default: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign eng_req  = (q_q.st == SQ_ISSUE);
    assign eng_addr = q_q.addr;
    assign busy     = (q_q.st != SQ_IDLE);
    assign done     = q_q.done;
    assign sig_ok   = q_q.ok;

    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5
    ok_rises_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_ok) |-> done);
    // R6
    retrig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && q_q.st == SQ_WAIT && !eng_done) |=> $stable(q_q.addr));
    // R2
    addr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_q.addr) |-> (q_q.addr == $past(q_q.addr) + AW'(1) || q_q.addr == '0));

endmodule

// File: rtl/ecl_regs.sv
module ecl_regs
    import eeprom_cfg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          clr,
    input  logic [AW-1:0] wr_idx,
    input  logic [15:0]   wr_data,
    output cfg_fields_t   fields
);
    cfg_fields_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d = FIELD_DEFAULTS;
        end else if (wr_en) begin
            case (wr_idx)
                AW'(W_SUBVEN): f_d.sub_vendor = wr_data;
                AW'(W_SUBID):  f_d.sub_id     = wr_data;
                AW'(W_TIMERS): begin
                    f_d.min_grant = wr_data[7:0];
                    f_d.max_lat   = wr_data[15:8];
                end
                AW'(W_MEDIA): begin
                    f_d.media = wr_data[7:0];
                    f_d.cfg3  = wr_data[15:8];
                end
                AW'(W_CFG01): begin
                    f_d.cfg0 = wr_data[7:0];
                    f_d.cfg1 = wr_data[15:8];
                end
                AW'(W_CFG4): f_d.cfg4 = wr_data[7:0];
                default: ;
            endcase
            for (int k = 0; k < STA_WORDS; k++) begin
                if (wr_idx == AW'(W_STA0 + k))
                    f_d.station[16*k +: 16] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= FIELD_DEFAULTS;
        end else begin
            f_q <= f_d;
        end
    end

    assign fields = f_q;

    // R12
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(fields));
    // R4
    clear_to_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fields == FIELD_DEFAULTS));

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import eeprom_cfg_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int AW       = 6,
    parameter int END_BYTE = 49
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        sig_ok,
    output logic        mw_cs,
    output logic        mw_sk,
    output logic        mw_do,
    input  logic        mw_di,
    output logic [15:0] vendor_id,
    output logic [15:0] device_id,
    output logic [15:0] sub_vendor_id,
    output logic [15:0] sub_id,
    output logic [7:0]  min_grant,
    output logic [7:0]  max_latency,
    output logic [7:0]  cfg0,
    output logic [7:0]  cfg1,
    output logic [7:0]  cfg3,
    output logic [7:0]  cfg4,
    output logic [7:0]  media_status,
    output logic [15:0] basic_ctl,
    output logic        adv_pause,
    output logic [47:0] station_addr
);
    localparam int LAST_WORD = END_BYTE / 2;

    logic          eng_req, eng_done, wr_en, clr;
    logic [AW-1:0] eng_addr;
    logic [15:0]   eng_data;
    cfg_fields_t   fields;

    ecl_serial #(.HALF_DIV(HALF_DIV), .AW(AW)) u_serial (
        .clk(clk), .rst_n(rst_n), .req(eng_req), .addr(eng_addr),
        .done(eng_done), .rdata(eng_data),
        .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_do(mw_do), .mw_di(mw_di)
    );

    ecl_seq #(.AW(AW), .LAST_WORD(LAST_WORD)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .eng_done(eng_done), .eng_data(eng_data),
        .eng_req(eng_req), .eng_addr(eng_addr),
        .wr_en(wr_en), .clr(clr),
        .busy(busy), .done(done), .sig_ok(sig_ok)
    );

    ecl_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr(clr),
        .wr_idx(eng_addr), .wr_data(eng_data), .fields(fields)
    );

    logic unused_media_bits;
    assign unused_media_bits = ^fields.media[3:2];

    assign vendor_id     = VENDOR_ID;
    assign device_id     = DEVICE_ID;
    assign sub_vendor_id = fields.sub_vendor;
    assign sub_id        = fields.sub_id;
    assign min_grant     = fields.min_grant;
    assign max_latency   = fields.max_lat;
    assign cfg0          = fields.cfg0;
    assign cfg1          = fields.cfg1;
    assign cfg3          = fields.cfg3;
    assign cfg4          = fields.cfg4;
    assign station_addr  = fields.station;
    assign media_status  = {fields.media[7:6], 6'b0};
    assign basic_ctl     = {2'b00, fields.media[5], fields.media[4], 3'b000,
                            fields.media[0], 8'h00};
    assign adv_pause     = fields.media[4] & ~fields.media[1];

    // R11
    pause_needs_autoneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_pause |-> basic_ctl[12]);

endmodule

// File: tb/eeprom_cfg_loader_tb.sv
module eeprom_cfg_loader_tb;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, sig_ok, mw_cs, mw_sk, mw_do;
    logic mw_di = 1'b0;
    logic [15:0] vendor_id, device_id, sub_vendor_id, sub_id, basic_ctl;
    logic [7:0]  min_grant, max_latency, cfg0, cfg1, cfg3, cfg4, media_status;
    logic        adv_pause;
    logic [47:0] station_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [7:0] mem [0:63];
    int run_base = 0;
    int frames = 0;
    int cmd_err = 0;
    int nbit = 0;
    int cur = 0;
    logic [8:0] cmdsh = '0;

    int lowcnt = 0;
    int gap_err = 0;
    int sk_err = 0;
    int per_err = 0;
    int per = 0;
    bit have_prev = 0;
    logic prev_cs = 1'b0;
    logic prev_sk = 1'b0;

    always #10 clk = ~clk;

    eeprom_cfg_loader #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .sig_ok(sig_ok), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_do(mw_do),
        .mw_di(mw_di), .vendor_id(vendor_id), .device_id(device_id),
        .sub_vendor_id(sub_vendor_id), .sub_id(sub_id), .min_grant(min_grant),
        .max_latency(max_latency), .cfg0(cfg0), .cfg1(cfg1), .cfg3(cfg3),
        .cfg4(cfg4), .media_status(media_status), .basic_ctl(basic_ctl),
        .adv_pause(adv_pause), .station_addr(station_addr)
    );

    // serial EEPROM model
    always @(posedge mw_sk or negedge mw_cs) begin
        if (!mw_cs) begin
            nbit = 0;
        end else begin
            if (nbit < 9) cmdsh = {cmdsh[7:0], mw_do};
            if (nbit == 8) begin
                if (cmdsh != {3'b110, 6'(frames - run_base)}) cmd_err++;
                cur = cmdsh[5:0];
                frames++;
            end
            if (nbit == 9) mw_di <= 1'b0;
            else if (nbit >= 10 && nbit < 26)
                mw_di <= (nbit < 18) ? mem[2*cur+1][17-nbit] : mem[2*cur][25-nbit];
            nbit++;
        end
    end

    // serial timing monitor
    always @(posedge clk) begin
        cycles++;
        if (!mw_cs && mw_sk) sk_err++;
        if (mw_cs && !prev_cs) begin
            if (lowcnt < 2*HALF) gap_err++;
            lowcnt = 0;
        end
        if (!mw_cs) begin
            lowcnt++;
            have_prev = 0;
        end
        per++;
        if (mw_sk && !prev_sk) begin
            if (have_prev && per != 2*HALF) per_err++;
            have_prev = 1;
            per = 0;
        end
        prev_cs = mw_cs;
        prev_sk = mw_sk;
        if (cycles == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed, input logic [7:0] media);
        for (int b = 0; b < 64; b++) mem[b] = 8'(b * 37 + seed * 13 + 5);
        mem[0] = 8'h29;
        mem[1] = 8'h81;
        mem[12] = media;
    endtask

    function automatic logic [47:0] exp_station();
        return {mem[8'h13], mem[8'h12], mem[8'h11], mem[8'h10], mem[8'h0F], mem[8'h0E]};
    endfunction

    task automatic check_fields(input bit good);
        logic [7:0] m;
        m = good ? mem[12] : 8'h00;
        chk("R7 vendor_id", vendor_id, 16'h10EC);
        chk("R7 device_id", device_id, 16'h8139);
        chk("R8 station_addr", station_addr, good ? exp_station() : 48'h0);
        chk("R9 sub_vendor_id", sub_vendor_id, good ? {mem[7], mem[6]} : 16'h0);
        chk("R9 sub_id", sub_id, good ? {mem[9], mem[8]} : 16'h0);
        chk("R9 min_grant", min_grant, good ? mem[10] : 8'h0);
        chk("R9 max_latency", max_latency, good ? mem[11] : 8'h0);
        chk("R9 cfg3", cfg3, good ? mem[13] : 8'h0);
        chk("R9 cfg0", cfg0, good ? mem[20] : 8'h0);
        chk("R9 cfg1", cfg1, good ? mem[21] : 8'h0);
        chk("R9 cfg4", cfg4, good ? mem[30] : 8'h0);
        chk("R10 media_status", media_status, {m[7:6], 6'b0});
        chk("R10 basic_ctl", basic_ctl, {2'b00, m[5], m[4], 3'b000, m[0], 8'h00});
        chk("R11 adv_pause", adv_pause, m[4] & ~m[1]);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk("R5 done seen", done, 1'b1);
        chk("R5 busy low at done", busy, 1'b0);
        @(negedge clk);
        chk("R5 done one cycle", done, 1'b0);
    endtask

    initial begin
        logic [47:0] old_sta;
        logic [7:0] m;
        fill(3, 8'h5A);
        mem[2] = 8'h11; mem[3] = 8'h22; mem[4] = 8'h33; mem[5] = 8'h44;
        repeat (5) @(negedge clk);
        chk("R1 busy in reset", busy, 1'b1);
        chk("R1 done in reset", done, 1'b0);
        chk("R1 cs in reset", mw_cs, 1'b0);
        chk("R1 station in reset", station_addr, 48'h0);
        chk("R1 basic_ctl in reset", basic_ctl, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 boot load busy", busy, 1'b1);
        wait_done();
        chk("R2 frame count", frames - run_base, 25);
        chk("R2 command errors", cmd_err, 0);
        chk("R5 sig_ok good", sig_ok, 1'b1);
        check_fields(1'b1);
        chk("R3 sk while cs low", sk_err, 0);
        chk("R3 cs gap", gap_err, 0);
        chk("R3 sk period", per_err, 0);

        // R12 / R6: second pattern, retrigger mid-run
        old_sta = exp_station();
        fill(11, 8'hC3);
        run_base = frames;
        pulse_start();
        chk("R5 busy after start", busy, 1'b1);
        begin
            int n;
            n = 0;
            while (frames - run_base < 8 && n < 20000) begin
                @(negedge clk);
                n++;
            end
        end
        chk("R12 station not yet loaded", station_addr, old_sta);
        chk("R12 sub_vendor already loaded", sub_vendor_id, {mem[7], mem[6]});
        pulse_start();
        wait_done();
        chk("R6 frames after retrigger", frames - run_base, 25);
        chk("R6 command errors", cmd_err, 0);
        check_fields(1'b1);

        // R4: swapped signature
        mem[0] = 8'h81;
        mem[1] = 8'h29;
        run_base = frames;
        pulse_start();
        wait_done();
        chk("R4 sig_ok low", sig_ok, 1'b0);
        chk("R4 single frame", frames - run_base, 1);
        check_fields(1'b0);

        // R10 / R11: media control-bit sweep
        for (int i = 0; i < 16; i++) begin
            m = {~i[1], ~i[0], i[3], i[2], i[0] ^ i[3], i[2], i[1], i[0]};
            fill(20 + i, m);
            run_base = frames;
            pulse_start();
            wait_done();
            chk("R5 sig_ok sweep", sig_ok, 1'b1);
            check_fields(1'b1);
        end
        chk("R2 command errors final", cmd_err, 0);
        chk("R3 timing errors final", gap_err + sk_err + per_err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule